// File: doc/BRIEF.md
# Gated Sound Control Register Bank

A bank of byte-wide sound control registers on a simple processor bus. It has an address, a write strobe with write data, and a read strobe with registered read data. The bank holds the settings for four sound channels and the output mixer. It also holds one power/status register whose top bit is the master enable for the whole sound unit. The stored fields and the master enable go out as a flat bus to the channel logic, which lives elsewhere. The channel logic sends back four per-channel active flags, and these show in the status nibble.

While the master enable is clear, writes to channel and mixer registers are refused. A model-select input picks monochrome behaviour, in which the channel length fields stay writable while powered down. Clearing the master enable wipes every channel and mixer register on the same clock edge. Reads OR each stored byte with a fixed per-register mask, so bits that cannot be read or that only exist for writing return as ones. Offsets in the bank that map to no register read as 0xFF.

Top module: `snd_regbank`

## Requirements
- R1: Register offsets, each with its read mask and its reset value (reset value 0x00 unless one is listed):

  | Offset | Register | Read mask | Reset value |
  |---|---|---|---|
  | 0 | ch1 sweep | 0x80 | 0x80 |
  | 1 | ch1 length/duty | 0x3F | 0xBF |
  | 2 | ch1 envelope | 0x00 | 0xF3 |
  | 3 | ch1 freq-low | 0xFF | |
  | 4 | ch1 freq-high/trigger | 0xBF | |
  | 5 | ch2 length/duty | 0x3F | |
  | 6 | ch2 envelope | 0x00 | |
  | 7 | ch2 freq-low | 0xFF | |
  | 8 | ch2 freq-high/trigger | 0xBF | |
  | 9 | ch3 DAC enable | 0x7F | |
  | 10 | ch3 length | 0xFF | |
  | 11 | ch3 volume | 0x9F | |
  | 12 | ch3 freq-low | 0xFF | |
  | 13 | ch3 freq-high/trigger | 0xBF | |
  | 14 | ch4 length | 0xFF | |
  | 15 | ch4 envelope | 0x00 | |
  | 16 | ch4 polynomial | 0x00 | |
  | 17 | ch4 control/trigger | 0xBF | |
  | 18 | master volume | 0x00 | 0x77 |
  | 19 | panning | 0x00 | 0xF3 |
  | 20 | power/status | see R3 | master enable set |

  Reset leaves exactly these values in place.
- R2: A read of offsets 0 to 19 returns the stored byte ORed with that register's read mask from R1.
- R3: A read of offset 20 returns {master enable, 3'b111, ch_active[3:0]}. A write to offset 20 takes only data bit 7, which becomes the master enable. The status nibble always comes from ch_active.
- R4: A write to offset 20 with bit 7 clear sets offsets 0 to 19 to 0x00 and clears the master enable, both on that same clock edge.
- R5: While the master enable is clear and mono_mode is 0, writes to offsets 0 to 19 leave the stored values unchanged.
- R6: While the master enable is clear and mono_mode is 1, a write to offset 1 or offset 5 stores data AND 0x3F.
- R7: While the master enable is clear and mono_mode is 1, a write to offset 10 or offset 14 stores the full data byte. Writes to any other channel or mixer offset are refused, as in R5.
- R8: A read of any offset from 21 up to the top of the address range returns 0xFF.
- R9: rd_data takes the read value on the clock edge where rd_en is high. rd_data holds its value while rd_en is low. Reset sets rd_data to 0x00.
- R10: reg_bus bits [8*i+7:8*i] carry the stored byte of offset i. master_en is the stored master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register offset within the bank |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| mono_mode | input | 1 | 1 selects monochrome-model write gating |
| ch_active | input | 4 | Per-channel active flags for the status nibble |
| master_en | output | 1 | Master sound enable |
| reg_bus | output | 8*21 | Stored register bytes, offset i in byte lane i |

## Verification
The assertions assume that the address, the strobes and mono_mode carry known values whenever reset is released. They also assume that mono_mode does not change in the same cycle as a write it is meant to gate. The stimulus drives every input on the falling clock edge and holds it for a full cycle, so each strobe is sampled exactly once. The mode is changed only between operations. Reads and writes never share a cycle in the stimulus, so the read value is always taken from settled register state.

// File: rtl/snd_regbank.sv
module snd_regbank #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic              mono_mode,
  input  logic [3:0]        ch_active,
  output logic              master_en,
  output logic [8*21-1:0]   reg_bus
);
  localparam int NREG = 21;
  localparam int PWR  = NREG - 1;

  logic [7:0] r [NREG];
  logic [7:0] rd_val;

  function automatic logic [7:0] rd_mask(input int i);
    case (i)
      0:               return 8'h80;
      1, 5:            return 8'h3F;
      3, 7, 10, 12, 14: return 8'hFF;
      4, 8, 13, 17:    return 8'hBF;
      9:               return 8'h7F;
      11:              return 8'h9F;
      PWR:             return 8'h70;
      default:         return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      0:       return 8'h80;
      1:       return 8'hBF;
      2:       return 8'hF3;
      18:      return 8'h77;
      19:      return 8'hF3;
      PWR:     return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  assign master_en = r[PWR][7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) r[i] <= rst_val(i);
    end else if (wr_en) begin
      if (addr == ADDR_W'(PWR)) begin
        r[PWR] <= {wr_data[7], 7'b0};
        if (!wr_data[7])
          for (int i = 0; i < PWR; i++) r[i] <= 8'h00;
      end else begin
        for (int i = 0; i < PWR; i++) begin
          if (addr == ADDR_W'(i)) begin
            if (master_en)
              r[i] <= wr_data;
            else if (mono_mode && (i == 1 || i == 5))
              r[i] <= wr_data & 8'h3F;
            else if (mono_mode && (i == 10 || i == 14))
              r[i] <= wr_data;
          end
        end
      end
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    for (int i = 0; i < PWR; i++)
      if (addr == ADDR_W'(i)) rd_val = r[i] | rd_mask(i);
    if (addr == ADDR_W'(PWR)) rd_val = r[PWR] | rd_mask(PWR) | {4'b0, ch_active};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_val;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bus
    assign reg_bus[g*8 +: 8] = r[g];
  end

  p_pwr_bit7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(PWR)) |=> (master_en == $past(wr_data[7])));

  p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(PWR) && !wr_data[7]) |=> (reg_bus[PWR*8-1:0] == '0 && !master_en));

  p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !master_en && !mono_mode && int'(addr) < PWR) |=> $stable(reg_bus));

  p_mono_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !master_en && mono_mode && (addr == ADDR_W'(1) || addr == ADDR_W'(5)))
      |=> (reg_bus[15:14] == 2'b00 && reg_bus[47:46] == 2'b00));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) >= NREG) |=> (rd_data == 8'hFF));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_snd_regbank.sv
module tb_snd_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  addr = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 0;
  logic [7:0]  rd_data;
  logic        mono_mode = 0;
  logic [3:0]  ch_active = 4'b0101;
  logic        master_en;
  logic [167:0] reg_bus;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  snd_regbank #(.ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .mono_mode(mono_mode),
    .ch_active(ch_active), .master_en(master_en), .reg_bus(reg_bus)
  );

  function automatic logic [7:0] exp_mask(input int i);
    case (i)
      0: return 8'h80;  1: return 8'h3F;  2: return 8'h00;  3: return 8'hFF;
      4: return 8'hBF;  5: return 8'h3F;  6: return 8'h00;  7: return 8'hFF;
      8: return 8'hBF;  9: return 8'h7F;  10: return 8'hFF; 11: return 8'h9F;
      12: return 8'hFF; 13: return 8'hBF; 14: return 8'hFF; 15: return 8'h00;
      16: return 8'h00; 17: return 8'hBF; default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  function automatic logic [7:0] lane(input int i);
    return reg_bus[i*8 +: 8];
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    check("R9 rd_data reset", rd_data, 8'h00);
    check("R10 master_en reset", {7'b0, master_en}, 8'h01);
    rd(0, d);  check("R1 sweep reset", d, 8'h80);
    rd(1, d);  check("R1 ch1 len reset", d, 8'hBF);
    rd(2, d);  check("R1 ch1 env reset", d, 8'hF3);
    rd(18, d); check("R1 volume reset", d, 8'h77);
    rd(19, d); check("R1 panning reset", d, 8'hF3);
    rd(20, d); check("R1 power reset", d, 8'hF5);
    check("R1 freq-low reset lane", lane(3), 8'h00);
  endtask

  task automatic t_masks;
    logic [7:0] d;
    for (int i = 0; i < 20; i++) begin
      wr(i, 8'h00);
      rd(i, d);
      check("R2 mask readback", d, exp_mask(i));
    end
    wr(2, 8'hA5); rd(2, d); check("R2 envelope full read", d, 8'hA5);
    wr(11, 8'h20); rd(11, d); check("R2 volume read", d, 8'hBF);
    check("R10 lane 11", lane(11), 8'h20);
  endtask

  task automatic t_power_status;
    logic [7:0] d;
    wr(20, 8'h8F);
    check("R3 enable kept", {7'b0, master_en}, 8'h01);
    ch_active = 4'b1010;
    rd(20, d); check("R3 status nibble", d, 8'hFA);
    check("R3 stored power lane", lane(20), 8'h80);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    bit ok;
    wr(7, 8'h12); wr(18, 8'h55);
    wr(20, 8'h00);
    check("R4 master off", {7'b0, master_en}, 8'h00);
    ok = (reg_bus[159:0] == '0);
    check("R4 all lanes zero", {7'b0, ok}, 8'h01);
    rd(18, d); check("R4 volume cleared", d, 8'h00);
    rd(20, d); check("R3 power read off", d, 8'h7A);
  endtask

  task automatic t_blocked_color;
    mono_mode = 0;
    wr(2, 8'h55);  check("R5 env blocked", lane(2), 8'h00);
    wr(1, 8'hFF);  check("R5 len blocked color", lane(1), 8'h00);
    wr(10, 8'hAB); check("R5 ch3 len blocked color", lane(10), 8'h00);
    wr(19, 8'hFF); check("R5 panning blocked", lane(19), 8'h00);
  endtask

  task automatic t_mono;
    mono_mode = 1;
    wr(1, 8'hFF);  check("R6 ch1 len low6", lane(1), 8'h3F);
    wr(5, 8'hC7);  check("R6 ch2 len low6", lane(5), 8'h07);
    wr(10, 8'hAB); check("R7 ch3 len full", lane(10), 8'hAB);
    wr(14, 8'h3C); check("R7 ch4 len full", lane(14), 8'h3C);
    wr(2, 8'h55);  check("R7 env still blocked", lane(2), 8'h00);
    mono_mode = 0;
  endtask

  task automatic t_reenable;
    logic [7:0] d;
    wr(20, 8'h80);
    check("R3 enable on", {7'b0, master_en}, 8'h01);
    wr(6, 8'h66); rd(6, d); check("R5 write after enable", d, 8'h66);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    rd(21, d); check("R8 offset 21", d, 8'hFF);
    rd(31, d); check("R8 offset 31", d, 8'hFF);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    rd(6, d);
    @(negedge clk); addr = 5'd21;
    @(negedge clk); addr = 5'd0;
    @(negedge clk);
    check("R9 hold without rd_en", rd_data, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_masks;
    t_power_status;
    t_clear;
    t_blocked_color;
    t_mono;
    t_reenable;
    t_unmapped;
    t_hold;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule